// File: doc/BRIEF.md
# Character LCD Scan Renderer

This block walks every character cell of a character LCD and produces one 5-pixel raster line per clock. For each cell it forms the display-memory address (with a horizontal display offset that wraps within each line), reads the character code, reads the matching raster line from the user glyph memory or from a fixed font table, and paints the underline and blinking block cursors over the cell whose address equals the cursor address. Two screen arrangements are supported: a linear 16-column by 2-line arrangement and an interleaved 20-column by 4-line arrangement.

The three memories sit outside the block and are read synchronously with one cycle of latency. The block provides their read addresses and receives their data. The output carries a valid strobe, the pixel pattern, and the line, column and raster coordinates of that pattern. A downstream LCD driver uses these values. Configuration inputs are expected to stay steady while a frame is being scanned.

Top module: `lcd_row_renderer`

## Requirements
- R1: With four_line_i low, line r (0 or 1) column c reads display address r*16 + ((c + disp_off_i) mod 16).
- R2: With four_line_i high, position p = (c + disp_off_i) mod 20 indexes this address list. For lines 0 and 1 the list is 00..03, 08..0F, 18..1F. For lines 2 and 3 the list is 04..07, 10..17, 20..27. Lines 1 and 3 add 0x40 to the address.
- R3: Every clock produces one output raster. Rasters run innermost, with 8 per cell when tall_font_i is low and 11 when it is high. Columns run next, 16 or 20 of them. Lines run outermost, 2 or 4 of them. After reset the scan starts at line 0, column 0, raster 0.
- R4: With tall_font_i low, codes 0x00..0x0F read glyph address (code mod 8)*8 + raster, so codes 0x08..0x0F alias 0x00..0x07.
- R5: With tall_font_i high, codes 0x00..0x0F read glyph address ((code>>1) mod 4)*16 + raster, for rasters 0..10.
- R6: Codes 0x10 and above read the font table at address code*16 + raster.
- R7: pix_o bit i equals bit i (for i = 0..4) of the fetched glyph byte. A 1 means a dark pixel. Bits 7..5 of the byte have no effect.
- R8: With ul_en_i high, the last raster of the cell whose address equals cursor_addr_i is all ones (0x1F).
- R9: With blk_en_i high, the cursor cell is bit-inverted during the blink "on" phase. The phase is on from reset and flips after every BLINK_FRAMES complete frames.
- R10: With both cursors enabled, the underline is applied first and the inversion second, so the last raster reads 0x00 during the on phase.
- R11: With disp_en_i low, pix_o is 0x00 for every raster, cursors included.
- R12: While rst_ni is low, valid_o is low and pix_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_en_i | input | 1 | Display enable |
| four_line_i | input | 1 | 1: 20x4 interleaved, 0: 16x2 |
| tall_font_i | input | 1 | 1: 11-raster cells, 0: 8-raster |
| ul_en_i | input | 1 | Underline cursor enable |
| blk_en_i | input | 1 | Blinking block cursor enable |
| disp_off_i | input | 7 | Horizontal display offset |
| cursor_addr_i | input | 7 | Display address of the cursor cell |
| dm_addr_o | output | 7 | Display memory read address |
| dm_data_i | input | 8 | Display memory data, one cycle after address |
| cg_addr_o | output | 6 | User glyph memory read address |
| cg_data_i | input | 8 | User glyph data, one cycle after address |
| rom_addr_o | output | 12 | Font table read address |
| rom_data_i | input | 8 | Font table data, one cycle after address |
| valid_o | output | 1 | Output raster valid |
| pix_o | output | 5 | Raster pixels, 1 = dark |
| cell_col_o | output | 5 | Column of the output cell |
| cell_row_o | output | 2 | Line of the output cell |
| raster_o | output | 4 | Raster index within the cell |

## Verification
The display memory holds a mix of user glyph codes, including the aliased 0x08..0x0F range, and font-table codes. The glyph bytes carry noise in bits 7..5, so a wrong glyph source, a missing alias fold or leaked upper bits each give a different pixel pattern. Both screen arrangements are run with offsets of 0, 5, 23 and 127, which separates a plain linear map from a correct modulo wrap and from the interleaved segment table. The cursor is tried underline-only, block-only over several blink periods, combined in tall-font mode, and with the display disabled. This separates the overlay ordering, the blink phase and the blanking from each other.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int unsigned ROW_W       = 2;
  localparam int unsigned COL_W       = 5;
  localparam int unsigned RAS_W       = 4;
  localparam int unsigned PIX_W       = 5;
  localparam int unsigned DM_AW       = 7;
  localparam int unsigned CODE_W      = 8;
  localparam int unsigned CG_AW       = 6;
  localparam int unsigned ROM_AW      = CODE_W + RAS_W;
  localparam int unsigned COLS_2L     = 16;
  localparam int unsigned COLS_4L     = 20;
  localparam int unsigned ROWS_2L     = 2;
  localparam int unsigned ROWS_4L     = 4;
  localparam int unsigned LAST_RAS_8  = 7;
  localparam int unsigned LAST_RAS_11 = 10;

  typedef struct packed {
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [RAS_W-1:0] ras;
    logic             blink;
    logic             hit;
  } cell_tag_t;
endpackage

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
  import lcd_scan_pkg::*;
#(
  parameter int unsigned BLINK_FRAMES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             four_line_i,
  input  logic             tall_font_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic [RAS_W-1:0] ras_o,
  output logic             blink_o
);
  localparam int unsigned FC_W = (BLINK_FRAMES > 1) ? $clog2(BLINK_FRAMES) : 1;

  logic [ROW_W-1:0] row_q, last_row;
  logic [COL_W-1:0] col_q, last_col;
  logic [RAS_W-1:0] ras_q, last_ras;
  logic [FC_W-1:0]  frm_q;
  logic             blink_q;

  assign last_ras = tall_font_i ? RAS_W'(LAST_RAS_11) : RAS_W'(LAST_RAS_8);
  assign last_col = four_line_i ? COL_W'(COLS_4L - 1) : COL_W'(COLS_2L - 1);
  assign last_row = four_line_i ? ROW_W'(ROWS_4L - 1) : ROW_W'(ROWS_2L - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q   <= '0;
      col_q   <= '0;
      ras_q   <= '0;
      frm_q   <= '0;
      blink_q <= 1'b1;
    end else if (ras_q >= last_ras) begin
      ras_q <= '0;
      if (col_q >= last_col) begin
        col_q <= '0;
        if (row_q >= last_row) begin
          row_q <= '0;
          // frame complete
          if (frm_q == FC_W'(BLINK_FRAMES - 1)) begin
            frm_q   <= '0;
            blink_q <= ~blink_q;
          end else begin
            frm_q <= frm_q + 1'b1;
          end
        end else begin
          row_q <= row_q + 1'b1;
        end
      end else begin
        col_q <= col_q + 1'b1;
      end
    end else begin
      ras_q <= ras_q + 1'b1;
    end
  end

  assign row_o   = row_q;
  assign col_o   = col_q;
  assign ras_o   = ras_q;
  assign blink_o = blink_q;
endmodule

// File: rtl/lcd_cell_addr.sv
module lcd_cell_addr
  import lcd_scan_pkg::*;
(
  input  logic             four_line_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [DM_AW-1:0] off_i,
  input  logic [DM_AW-1:0] cursor_i,
  output logic [DM_AW-1:0] addr_o,
  output logic             hit_o
);
  logic [7:0]       sum;
  logic [COL_W-1:0] pos;
  logic [5:0]       seg_add;
  logic [5:0]       lo;

  always_comb begin
    sum = 8'(off_i) + 8'(col_i);
    pos = four_line_i ? COL_W'(sum % 8'(COLS_4L)) : COL_W'(sum[3:0]);
    // interleaved segments: 4 + 8 + 8 cells per line
    if (pos < COL_W'(4))       seg_add = 6'd0;
    else if (pos < COL_W'(12)) seg_add = 6'd4;
    else                       seg_add = 6'd12;
    if (row_i[1]) seg_add = seg_add + ((pos < COL_W'(4)) ? 6'd4 : 6'd8);
    lo = 6'(pos) + seg_add;
    if (four_line_i) addr_o = {row_i[0], lo};
    else             addr_o = DM_AW'({row_i[0], pos[3:0]});
  end

  assign hit_o = (addr_o == cursor_i);
endmodule

// File: rtl/lcd_glyph_addr.sv
module lcd_glyph_addr
  import lcd_scan_pkg::*;
(
  input  logic              tall_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [RAS_W-1:0]  ras_i,
  output logic [CG_AW-1:0]  cg_addr_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              user_o
);
  assign user_o     = (code_i[CODE_W-1:4] == '0);
  assign cg_addr_o  = tall_i ? {code_i[2:1], ras_i} : {code_i[2:0], ras_i[2:0]};
  assign rom_addr_o = {code_i, ras_i};
endmodule

// File: rtl/lcd_pix_overlay.sv
module lcd_pix_overlay
  import lcd_scan_pkg::*;
(
  input  logic              en_i,
  input  logic              ul_en_i,
  input  logic              blk_en_i,
  input  logic              tall_i,
  input  cell_tag_t         tag_i,
  input  logic              user_i,
  input  logic [CODE_W-1:0] cg_data_i,
  input  logic [CODE_W-1:0] rom_data_i,
  output logic [PIX_W-1:0]  pix_o
);
  logic             last_ras;
  logic [PIX_W-1:0] glyph;
  logic             unused_hi;

  assign unused_hi = ^{cg_data_i[CODE_W-1:PIX_W], rom_data_i[CODE_W-1:PIX_W]};
  assign last_ras  = tag_i.ras == (tall_i ? RAS_W'(LAST_RAS_11) : RAS_W'(LAST_RAS_8));

  always_comb begin
    glyph = user_i ? cg_data_i[PIX_W-1:0] : rom_data_i[PIX_W-1:0];
    if (tag_i.hit && ul_en_i && last_ras) glyph = '1;
    if (tag_i.hit && blk_en_i && tag_i.blink) glyph = ~glyph;
    pix_o = en_i ? glyph : '0;
  end
endmodule

// File: rtl/lcd_row_renderer.sv
module lcd_row_renderer
  import lcd_scan_pkg::*;
#(
  parameter int unsigned BLINK_FRAMES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_en_i,
  input  logic              four_line_i,
  input  logic              tall_font_i,
  input  logic              ul_en_i,
  input  logic              blk_en_i,
  input  logic [DM_AW-1:0]  disp_off_i,
  input  logic [DM_AW-1:0]  cursor_addr_i,
  output logic [DM_AW-1:0]  dm_addr_o,
  input  logic [CODE_W-1:0] dm_data_i,
  output logic [CG_AW-1:0]  cg_addr_o,
  input  logic [CODE_W-1:0] cg_data_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [CODE_W-1:0] rom_data_i,
  output logic              valid_o,
  output logic [PIX_W-1:0]  pix_o,
  output logic [COL_W-1:0]  cell_col_o,
  output logic [ROW_W-1:0]  cell_row_o,
  output logic [RAS_W-1:0]  raster_o
);
  logic [ROW_W-1:0] row0;
  logic [COL_W-1:0] col0;
  logic [RAS_W-1:0] ras0;
  logic             blink0, hit0, user1, user2;
  logic             v1, v2, valid_q;
  cell_tag_t        tag0, tag1, tag2;
  logic [PIX_W-1:0] pix_c, pix_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [RAS_W-1:0] ras_q;

  lcd_scan_seq #(.BLINK_FRAMES(BLINK_FRAMES)) u_seq (
    .clk_i, .rst_ni, .four_line_i, .tall_font_i,
    .row_o(row0), .col_o(col0), .ras_o(ras0), .blink_o(blink0)
  );

  // stage 0: display address
  lcd_cell_addr u_addr (
    .four_line_i, .row_i(row0), .col_i(col0), .off_i(disp_off_i),
    .cursor_i(cursor_addr_i), .addr_o(dm_addr_o), .hit_o(hit0)
  );

  assign tag0 = '{row: row0, col: col0, ras: ras0, blink: blink0, hit: hit0};

  // stage 1: code returned, glyph address
  lcd_glyph_addr u_gaddr (
    .tall_i(tall_font_i), .code_i(dm_data_i), .ras_i(tag1.ras),
    .cg_addr_o, .rom_addr_o, .user_o(user1)
  );

  // stage 2: glyph returned, overlay
  lcd_pix_overlay u_ovl (
    .en_i(disp_en_i), .ul_en_i, .blk_en_i, .tall_i(tall_font_i),
    .tag_i(tag2), .user_i(user2), .cg_data_i, .rom_data_i, .pix_o(pix_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1      <= 1'b0;
      v2      <= 1'b0;
      valid_q <= 1'b0;
      tag1    <= '0;
      tag2    <= '0;
      user2   <= 1'b0;
      pix_q   <= '0;
      col_q   <= '0;
      row_q   <= '0;
      ras_q   <= '0;
    end else begin
      v1      <= 1'b1;
      tag1    <= tag0;
      v2      <= v1;
      tag2    <= tag1;
      user2   <= user1;
      valid_q <= v2;
      pix_q   <= pix_c;
      col_q   <= tag2.col;
      row_q   <= tag2.row;
      ras_q   <= tag2.ras;
    end
  end

  assign valid_o    = valid_q;
  assign pix_o      = pix_q;
  assign cell_col_o = col_q;
  assign cell_row_o = row_q;
  assign raster_o   = ras_q;
endmodule

// File: rtl/lcd_row_renderer_chk.sv
module lcd_row_renderer_chk
  import lcd_scan_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              disp_en_i,
  input logic              four_line_i,
  input logic              tall_font_i,
  input logic [DM_AW-1:0]  dm_addr_o,
  input logic [CG_AW-1:0]  cg_addr_o,
  input logic              valid_o,
  input logic [PIX_W-1:0]  pix_o,
  input logic [COL_W-1:0]  cell_col_o,
  input logic [ROW_W-1:0]  cell_row_o,
  input logic [RAS_W-1:0]  raster_o
);
  AST_DM_ADDR_LINEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !four_line_i |-> dm_addr_o < 7'h20); // R1
  AST_DM_ADDR_INTERLEAVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    four_line_i |-> dm_addr_o[5:0] < 6'h28); // R2
  AST_RASTER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> raster_o <= (tall_font_i ? 4'd10 : 4'd7)); // R3
  AST_CELL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !four_line_i) |-> (cell_col_o <= 5'd15 && cell_row_o <= 2'd1)); // R3
  AST_COL_BOUND_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && four_line_i) |-> cell_col_o <= 5'd19); // R3
  AST_RASTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && raster_o != 4'd0) |-> raster_o == $past(raster_o) + 4'd1); // R3
  AST_TALL_GLYPH_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tall_font_i |-> cg_addr_o[3:0] <= 4'd10); // R5
  AST_BLANK_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_en_i |=> pix_o == 5'd0); // R11
endmodule

bind lcd_row_renderer lcd_row_renderer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .disp_en_i(disp_en_i), .four_line_i(four_line_i),
  .tall_font_i(tall_font_i), .dm_addr_o(dm_addr_o), .cg_addr_o(cg_addr_o),
  .valid_o(valid_o), .pix_o(pix_o), .cell_col_o(cell_col_o),
  .cell_row_o(cell_row_o), .raster_o(raster_o)
);

// File: tb/tb_lcd_row_renderer.sv
`timescale 1ns/1ps
module tb_lcd_row_renderer;
  localparam int BLINK = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en, four, tall, ul, blk;
  logic [6:0]  off, cur;
  logic [6:0]  dm_addr;
  logic [5:0]  cg_addr;
  logic [11:0] rom_addr;
  logic [7:0]  dm_q, cg_q, rom_q;
  logic        valid;
  logic [4:0]  pix, col;
  logic [1:0]  row;
  logic [3:0]  ras;

  logic [7:0] dm_mem [128];
  logic [7:0] cg_mem [64];

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  lcd_row_renderer #(.BLINK_FRAMES(BLINK)) dut (
    .clk_i(clk), .rst_ni(rst_n), .disp_en_i(en), .four_line_i(four),
    .tall_font_i(tall), .ul_en_i(ul), .blk_en_i(blk), .disp_off_i(off),
    .cursor_addr_i(cur), .dm_addr_o(dm_addr), .dm_data_i(dm_q),
    .cg_addr_o(cg_addr), .cg_data_i(cg_q), .rom_addr_o(rom_addr), .rom_data_i(rom_q),
    .valid_o(valid), .pix_o(pix), .cell_col_o(col), .cell_row_o(row), .raster_o(ras)
  );

  function automatic logic [7:0] rom_fn(input int a);
    int v = a * 53 + 17;
    return 8'(v ^ (v >> 5));
  endfunction

  // synchronous-read memory models
  always @(posedge clk) begin
    dm_q  <= dm_mem[dm_addr];
    cg_q  <= cg_mem[cg_addr];
    rom_q <= rom_fn(int'(rom_addr));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R1 R2 expected display address
  function automatic int exp_addr(input int r, input int c);
    int ncols = four ? 20 : 16;
    int p = (c + int'(off)) % ncols;
    int lst[$];
    if (!four) return r * 16 + p;
    if (r < 2) begin
      for (int k = 0; k < 4; k++)   lst.push_back(k);
      for (int k = 8; k < 16; k++)  lst.push_back(k);
      for (int k = 24; k < 32; k++) lst.push_back(k);
    end else begin
      for (int k = 4; k < 8; k++)   lst.push_back(k);
      for (int k = 16; k < 24; k++) lst.push_back(k);
      for (int k = 32; k < 40; k++) lst.push_back(k);
    end
    return lst[p] + ((r % 2 == 1) ? 64 : 0);
  endfunction

  function automatic int exp_pix(input int r, input int c, input int rs, input int frame);
    int a = exp_addr(r, c);
    int code = int'(dm_mem[a]);
    int last = tall ? 10 : 7;
    int g;
    if (code < 16) begin
      if (tall) g = int'(cg_mem[((code >> 1) % 4) * 16 + rs]);   // R5
      else      g = int'(cg_mem[(code % 8) * 8 + rs]);          // R4
    end else begin
      g = int'(rom_fn(code * 16 + rs));                         // R6
    end
    g = g & 31;                                                 // R7
    if (a == int'(cur)) begin
      if (ul && rs == last) g = 31;                             // R8
      if (blk && ((frame / BLINK) % 2 == 0)) g = g ^ 31;        // R9 R10
    end
    if (!en) g = 0;                                             // R11
    return g;
  endfunction

  task automatic run(input bit e, input bit f, input bit t, input bit u, input bit b,
                     input int o, input int cu, input int frames, input string req);
    int er = 0, ec = 0, es = 0, fc = 0;
    int last_r, ncols, nrows, ep;
    @(negedge clk);
    rst_n = 1'b0;
    en = e; four = f; tall = t; ul = u; blk = b;
    off = 7'(o); cur = 7'(cu);
    repeat (2) @(negedge clk);
    chk(valid == 1'b0 && pix == 5'd0, "R12", {27'd0, valid, pix}, 0);
    rst_n = 1'b1;
    last_r = t ? 10 : 7;
    ncols  = f ? 20 : 16;
    nrows  = f ? 4 : 2;
    while (fc < frames && !done) begin
      @(negedge clk);
      if (valid) begin
        chk(int'(row) == er && int'(col) == ec && int'(ras) == es, "R3",
            int'({row, col, ras}), (er << 9) | (ec << 4) | es);
        ep = exp_pix(er, ec, es, fc);
        chk(int'(pix) == ep, req, int'(pix), ep);
        es++;
        if (es > last_r) begin
          es = 0; ec++;
          if (ec == ncols) begin
            ec = 0; er++;
            if (er == nrows) begin er = 0; fc++; end
          end
        end
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 128; i++)
      dm_mem[i] = (i % 3 == 0) ? 8'(i % 16) : 8'(16 + (i * 7) % 240);
    for (int i = 0; i < 64; i++)
      cg_mem[i] = 8'(i * 29 + 3);
    en = 1; four = 0; tall = 0; ul = 0; blk = 0; off = '0; cur = '0;
    run(1, 0, 0, 0, 0, 0,   8'h00, 1, "R1 R4 R6 R7");
    run(1, 0, 0, 1, 0, 5,   8'h13, 1, "R1 R8");
    run(1, 1, 0, 0, 1, 0,   8'h45, 5, "R2 R9");
    run(1, 1, 1, 1, 1, 23,  8'h20, 3, "R2 R5 R10");
    run(0, 0, 0, 1, 1, 0,   8'h00, 1, "R11");
    run(1, 0, 1, 1, 0, 127, 8'h1F, 1, "R1 R5");
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule